// File: doc/BRIEF.md
# Nonvolatile Wiper Save Controller

This controller sits beside a 64-step digital potentiometer and decides when the live wiper position gets copied into a nonvolatile word. When power becomes good, it first reads the stored word back and makes it the live position. Position updates then arrive on a valid/ready stream. Each accepted value drives the wiper on the next cycle, and save activity never holds it back.

To limit write wear, a save is armed only in two cases. The first is the first change after a restore, whatever that change is. The second is, afterwards, a change that makes bit 3 of the live position differ from bit 3 of the last stored word. An armed save goes out only after the position has been stable for a settle delay. That delay is counted in clock-enable ticks, nominally worth two seconds. The storage port takes one write at a time through a request/done handshake. The restore uses a read request/done pair.

The stream's back-pressure rule is simple: `pos_ready` is high only while the controller is running, which means after a restore and while power is good. During power-down and during the restore it is low, and offered values are not taken. A saturating count of completed writes is provided so wear can be observed.

Top module: `wiper_save_ctrl`

## Requirements
- R1: From the cycle after `pwr_good` rises, `nv_rd_req` stays high until `nv_rd_done`. On that edge, `wiper_pos` and the stored-value reference take `nv_rdata`, and `pos_ready` goes high.
- R2: A value is accepted when `pos_valid` and `pos_ready` are both high. It appears on `wiper_pos` one cycle later, including while a write is outstanding. `pos_ready` is low before the restore completes and while `pwr_good` is low, and offered values are then ignored.
- R3: The first accepted value after a restore that differs from `wiper_pos` arms a save, regardless of its bits.
- R4: After the first completed write, a change arms a save only when bit 3 (weight 8) of the new position differs from bit 3 of the last written word. Otherwise no write follows.
- R5: `nv_req` rises after exactly DELAY_TICKS ticks plus one cycle following the last change that kept a save armed. Each further accepted change restarts the count from zero.
- R6: If the position returns to a value whose bit 3 matches the last written word before the delay ends, the armed save is dropped. This does not apply while the first-change condition holds.
- R7: `nv_req` stays high with a stable `nv_wdata` until `nv_done`. `nv_wdata` equals `wiper_pos` at launch, and only one write is outstanding at a time.
- R8: On `nv_done`, the written word becomes the reference. If bit 3 of the live position then differs from it, a new save is armed and the delay starts from that edge.
- R9: One cycle after `pwr_good` is low, `nv_req` and `pos_ready` are low, `wiper_pos` is 0 and any armed save is gone. A restore runs again when `pwr_good` returns.
- R10: `wr_count` increases by one on each completed write and holds at its all-ones maximum.
- R11: `nv_req` and `nv_rd_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable for the settle timer |
| pwr_good | input | 1 | Supply good; low forces power-down state |
| pos_valid | input | 1 | Position stream valid |
| pos_ready | output | 1 | Position stream ready |
| pos_data | input | POS_W | Requested wiper position |
| wiper_pos | output | POS_W | Live wiper position |
| nv_rd_req | output | 1 | Restore read request |
| nv_rd_done | input | 1 | Restore read complete |
| nv_rdata | input | POS_W | Stored word returned by the read |
| nv_req | output | 1 | Write request |
| nv_wdata | output | POS_W | Word to write |
| nv_done | input | 1 | Write complete |
| wr_count | output | WCNT_W | Saturating count of completed writes |

## Verification
An accepted position shows on `wiper_pos` one cycle after its accepting edge. A save request rises DELAY_TICKS+1 edges after the last arming change, or after the `nv_done` that re-armed it. The bench samples at the falling edge, checks that `nv_req` is still low after DELAY_TICKS edges, and checks that it is high one edge later. The restore result and the power-down clearing are both checked one edge after `nv_rd_done` or after `pwr_good` drops.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RESTORE = 2'd1,
    ST_RUN     = 2'd2
  } wsc_state_e;
endpackage

// File: rtl/wsc_settle_timer.sv
module wsc_settle_timer #(
  parameter int DELAY_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && tick && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/wsc_save_policy.sv
module wsc_save_policy #(
  parameter int POS_W     = 6,
  parameter int TRACK_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             restore_ld,
  input  logic [POS_W-1:0] restore_val,
  input  logic             change,
  input  logic [POS_W-1:0] new_pos,
  input  logic             busy,
  input  logic             launch,
  input  logic             done_evt,
  input  logic [POS_W-1:0] done_val,
  input  logic [POS_W-1:0] live_next,
  output logic             pending
);
  logic [POS_W-1:0] ref_q;
  logic             first_q;
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (abort) begin
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (restore_ld) begin
      ref_q   <= restore_val;
      first_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (done_evt) begin
      ref_q   <= done_val;
      first_q <= 1'b0;
      pend_q  <= (live_next[TRACK_BIT] != done_val[TRACK_BIT]);
    end else if (launch) begin
      pend_q  <= 1'b0;
    end else if (change && !busy) begin
      if (first_q) pend_q <= 1'b1;
      else         pend_q <= (new_pos[TRACK_BIT] != ref_q[TRACK_BIT]);
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/wsc_sat_counter.sv
module wsc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (inc && (count != '1))  count <= count + 1'b1;
  end
endmodule

// File: rtl/wiper_save_ctrl.sv
module wiper_save_ctrl
  import wsc_pkg::*;
#(
  parameter int POS_W       = 6,
  parameter int TRACK_BIT   = 3,
  parameter int DELAY_TICKS = 500,
  parameter int WCNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_good,
  input  logic              pos_valid,
  output logic              pos_ready,
  input  logic [POS_W-1:0]  pos_data,
  output logic [POS_W-1:0]  wiper_pos,
  output logic              nv_rd_req,
  input  logic              nv_rd_done,
  input  logic [POS_W-1:0]  nv_rdata,
  output logic              nv_req,
  output logic [POS_W-1:0]  nv_wdata,
  input  logic              nv_done,
  output logic [WCNT_W-1:0] wr_count
);
  wsc_state_e       state_q;
  logic [POS_W-1:0] wiper_q;
  logic [POS_W-1:0] wdata_q;
  logic             req_q;

  logic             accept, change, done_evt, restore_ld, launch;
  logic             pending, expired, timer_clr, timer_run;
  logic [POS_W-1:0] live_next;

  assign pos_ready  = (state_q == ST_RUN);
  assign nv_rd_req  = (state_q == ST_RESTORE);
  assign accept     = pos_valid && pos_ready && pwr_good;
  assign change     = accept && (pos_data != wiper_q);
  assign live_next  = accept ? pos_data : wiper_q;
  assign done_evt   = req_q && nv_done && pwr_good;
  assign restore_ld = (state_q == ST_RESTORE) && nv_rd_done && pwr_good;
  assign launch     = (state_q == ST_RUN) && pwr_good && pending &&
                      !req_q && expired && !change;
  assign timer_clr  = change || done_evt || launch || restore_ld || !pwr_good;
  assign timer_run  = pending && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      wiper_q <= '0;
      wdata_q <= '0;
      req_q   <= 1'b0;
    end else if (!pwr_good) begin
      state_q <= ST_OFF;
      wiper_q <= '0;
      req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF:     state_q <= ST_RESTORE;
        ST_RESTORE: if (nv_rd_done) begin
                      state_q <= ST_RUN;
                      wiper_q <= nv_rdata;
                    end
        ST_RUN:     wiper_q <= live_next;
        default:    state_q <= ST_OFF;
      endcase
      if (launch) begin
        req_q   <= 1'b1;
        wdata_q <= wiper_q;
      end else if (done_evt) begin
        req_q   <= 1'b0;
      end
    end
  end

  wsc_save_policy #(.POS_W(POS_W), .TRACK_BIT(TRACK_BIT)) u_policy (
    .clk(clk), .rst_n(rst_n), .abort(!pwr_good),
    .restore_ld(restore_ld), .restore_val(nv_rdata),
    .change(change), .new_pos(pos_data), .busy(req_q),
    .launch(launch), .done_evt(done_evt), .done_val(wdata_q),
    .live_next(live_next), .pending(pending)
  );

  wsc_settle_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .run(timer_run),
    .tick(tick), .expired(expired)
  );

  wsc_sat_counter #(.W(WCNT_W)) u_wcnt (
    .clk(clk), .rst_n(rst_n), .inc(done_evt), .count(wr_count)
  );

  assign wiper_pos = wiper_q;
  assign nv_req    = req_q;
  assign nv_wdata  = wdata_q;
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int POS_W  = 6,
  parameter int WCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              pos_valid,
  input logic              pos_ready,
  input logic [POS_W-1:0]  pos_data,
  input logic [POS_W-1:0]  wiper_pos,
  input logic              nv_rd_req,
  input logic              nv_rd_done,
  input logic [POS_W-1:0]  nv_rdata,
  input logic              nv_req,
  input logic [POS_W-1:0]  nv_wdata,
  input logic              nv_done,
  input logic [WCNT_W-1:0] wr_count
);
  a_r1_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd_req && nv_rd_done && pwr_good |=> pos_ready && (wiper_pos == $past(nv_rdata)));

  a_r2_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid && pos_ready && pwr_good |=> (wiper_pos == $past(pos_data)));

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req && !nv_done && pwr_good |=> nv_req);

  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req && !nv_done && pwr_good |=> $stable(nv_wdata));

  a_r9_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !nv_req && !pos_ready && (wiper_pos == '0));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req && nv_done && pwr_good && (wr_count != '1) |=> wr_count == $past(wr_count) + 1'b1);

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_req && nv_done) |=> $stable(wr_count));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_req && nv_rd_req));
endmodule

bind wiper_save_ctrl wsc_checker #(.POS_W(POS_W), .WCNT_W(WCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pos_valid(pos_valid),
  .pos_ready(pos_ready), .pos_data(pos_data), .wiper_pos(wiper_pos),
  .nv_rd_req(nv_rd_req), .nv_rd_done(nv_rd_done), .nv_rdata(nv_rdata),
  .nv_req(nv_req), .nv_wdata(nv_wdata), .nv_done(nv_done), .wr_count(wr_count)
);

// File: tb/wiper_save_ctrl_test.sv
module wiper_save_ctrl_test;
  localparam int D  = 6;
  localparam int PW = 6;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic pwr_good = 1'b0;
  logic pos_valid = 1'b0;
  logic pos_ready;
  logic [PW-1:0] pos_data = '0;
  logic [PW-1:0] wiper_pos;
  logic nv_rd_req, nv_rd_done = 1'b0;
  logic [PW-1:0] nv_rdata = '0;
  logic nv_req, nv_done = 1'b0;
  logic [PW-1:0] nv_wdata;
  logic [CW-1:0] wr_count;

  int checks = 0;
  int fails  = 0;
  int nwr    = 0;

  always #2 clk = ~clk;

  wiper_save_ctrl #(.POS_W(PW), .TRACK_BIT(3), .DELAY_TICKS(D), .WCNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good),
    .pos_valid(pos_valid), .pos_ready(pos_ready), .pos_data(pos_data),
    .wiper_pos(wiper_pos), .nv_rd_req(nv_rd_req), .nv_rd_done(nv_rd_done),
    .nv_rdata(nv_rdata), .nv_req(nv_req), .nv_wdata(nv_wdata),
    .nv_done(nv_done), .wr_count(wr_count)
  );

  // {write expected, position}; restore value is 5
  localparam logic [6:0] VEC [8] = '{
    {1'b1, 6'd6},  {1'b0, 6'd7},  {1'b1, 6'd9},  {1'b0, 6'd14},
    {1'b1, 6'd1},  {1'b1, 6'd63}, {1'b0, 6'd56}, {1'b1, 6'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [PW-1:0] v);
    @(negedge clk);
    pos_valid = 1'b1;
    pos_data  = v;
    @(negedge clk);
    pos_valid = 1'b0;
  endtask

  task automatic serve();
    @(negedge clk);
    nv_done = 1'b1;
    @(negedge clk);
    nv_done = 1'b0;
    nwr++;
    check(nv_req == 1'b0, "R7 req drops on done", int'(nv_req), 0);
    check(int'(wr_count) == ((nwr > 3) ? 3 : nwr), "R10 write count", int'(wr_count),
          (nwr > 3) ? 3 : nwr);
  endtask

  // after apply(): checks request timing, returns with request high if expected
  task automatic expect_save(input bit exp, input logic [PW-1:0] data, input string req);
    repeat (D) @(negedge clk);
    check(nv_req == 1'b0, "R5 no early request", int'(nv_req), 0);
    @(negedge clk);
    check(nv_req == exp, req, int'(nv_req), int'(exp));
    if (exp) check(nv_wdata == data, "R7 write data", int'(nv_wdata), int'(data));
  endtask

  task automatic restore(input logic [PW-1:0] v);
    pwr_good = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(nv_rd_req == 1'b1, "R1 read request", int'(nv_rd_req), 1);
    check(pos_ready == 1'b0, "R2 not ready in restore", int'(pos_ready), 0);
    nv_rd_done = 1'b1;
    nv_rdata   = v;
    @(negedge clk);
    nv_rd_done = 1'b0;
    check(wiper_pos == v, "R1 restored position", int'(wiper_pos), int'(v));
    check(pos_ready == 1'b1, "R1 ready after restore", int'(pos_ready), 1);
    check(nv_rd_req == 1'b0, "R1 read request drops", int'(nv_rd_req), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(nv_req == 1'b0 && nv_rd_req == 1'b0, "R9 reset idle", int'(nv_req), 0);
    check(pos_ready == 1'b0 && wiper_pos == 0, "R2 reset not ready", int'(pos_ready), 0);
    check(wr_count == 0, "R10 reset count", int'(wr_count), 0);

    restore(6'd5);

    // vector walk: R3 first change, R4 bit-3 policy, R10 saturation
    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][5:0]);
      check(wiper_pos == VEC[i][5:0], "R2 position applied", int'(wiper_pos), int'(VEC[i][5:0]));
      expect_save(VEC[i][6], VEC[i][5:0], (i == 0) ? "R3 first change saves" : "R4 bit3 policy");
      if (VEC[i][6]) serve();
    end

    // R5 restart: second change inside the window delays the write
    apply(6'd8);
    repeat (D - 2) @(negedge clk);
    apply(6'd12);
    expect_save(1'b1, 6'd12, "R5 timer restart");
    serve();

    // R6 cancel: return to bit-3 match before expiry
    apply(6'd3);
    repeat (2) @(negedge clk);
    apply(6'd15);
    repeat (D + 3) @(negedge clk);
    check(nv_req == 1'b0, "R6 save cancelled", int'(nv_req), 0);

    // R8 change during an outstanding write re-arms after done
    apply(6'd2);
    expect_save(1'b1, 6'd2, "R4 save bit3 cleared");
    apply(6'd10);
    check(wiper_pos == 6'd10, "R2 update during write", int'(wiper_pos), 10);
    check(nv_wdata == 6'd2, "R7 data held", int'(nv_wdata), 2);
    serve();
    expect_save(1'b1, 6'd10, "R8 re-armed after done");
    serve();

    // R9 power drop aborts armed save
    apply(6'd20);
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    check(nv_req == 1'b0 && pos_ready == 1'b0, "R9 drop clears", int'(pos_ready), 0);
    check(wiper_pos == 0, "R9 position cleared", int'(wiper_pos), 0);
    apply(6'd50);
    check(wiper_pos == 0, "R2 ignored while off", int'(wiper_pos), 0);
    repeat (D + 3) @(negedge clk);
    check(nv_req == 1'b0 && nv_rd_req == 1'b0, "R9 no write while off", int'(nv_req), 0);

    restore(6'd33);
    apply(6'd34);
    expect_save(1'b1, 6'd34, "R3 first change after repower");
    check(nv_rd_req == 1'b0, "R11 exclusive", int'(nv_rd_req), 0);
    serve();

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule